// File: doc/BRIEF.md
# Addressed Serial Receiver with ID Hunting

This block receives asynchronous serial frames on a single line and hands each byte to a host through a small register port. Every frame carries, after its eight data bits, an extra flag bit that tells a station-ID frame (flag 1) apart from a data frame (flag 0). Several stations can share one line this way.

A host sets the hunt bit when it wants only the next station ID. While hunting, the receiver drops data frames in hardware. The first ID frame is stored and clears the hunt bit, so the data frames that follow it are stored as well. The host compares the stored ID with its own. On a mismatch it sets the hunt bit again and clears the full flag. Overrun and framing errors are sticky. While either one is set, reception stops until the host clears both. The synchronized line level can be read, so a break can be told apart from a plain framing error. Bit timing comes from an external 16x oversampling strobe.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x00, and the status register reads 0x08 (all flags 0, idle line level 1).
- R2: A frame is a start bit (0), 8 data bits sent LSB first, the ID flag bit, and a stop bit (1), each 16 strobes long and sampled at mid-bit. When the frame is stored, the data register (address 0) holds the byte and the full flag (status bit 0, address 1) is set.
- R3: While the hunt bit (control bit 1, address 2) is 1, a frame with ID flag 0 is dropped: the data register, status flags and control register do not change.
- R4: A frame with ID flag 1 that is stored clears the hunt bit. Later data frames are then stored.
- R5: Writing 0 to status bit 0 (full), bit 1 (overrun) or bit 2 (framing error) clears that flag. Writing 1 to any of them has no effect.
- R6: A good frame that arrives while the full flag is 1 sets the overrun flag and is lost. The data register keeps the earlier byte.
- R7: A frame whose stop bit samples as 0 sets the framing error flag. The data register and the full flag are not changed.
- R8: While the overrun or framing error flag is 1, no frame is received. Reception resumes once both flags are 0.
- R9: While the receive-enable bit (control bit 0) is 0, nothing is received. Clearing it in the middle of a frame drops that frame.
- R10: Status bit 3 gives the synchronized line level, so a line held low reads 0 there.
- R11: A low pulse that is no longer low at the middle of the start bit is taken as noise and does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line |
| os_tick | input | 1 | 16x oversampling strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (1 status, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 data, 1 status, 2 control) |
| rd_data | output | 8 | Read data, combinational |
| rx_full | output | 1 | Full flag |
| rx_overrun | output | 1 | Overrun flag |
| rx_frame_err | output | 1 | Framing error flag |
| line_level | output | 1 | Synchronized line level |

## Verification
The assertions check on every cycle that the frame engine returns to idle when it is disabled or locked out, that a completion pulse comes only out of the bit-shifting state, that sticky error flags change only on a clearing write, that the data byte stays put while the full flag is held, and that the hunt filter and the ID self-clear act on a completed frame. Only the bench scenarios can show that bits are assembled in the right order at mid-bit, that a noise pulse leaves the engine in step for the next frame, that reception resumes after the flags are cleared, and that a held-low line shows up as a break. The bench runs directed cases and then a seeded random mix of IDs, data frames, bad stop bits and host actions, checked against a reference model.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
    parameter int DATA_W = 8;
    parameter int REG_W  = 8;
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_BITS  = 2'd2
    } fr_state_e;
endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = din;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/mprx_frame.sv
module mprx_frame
    import mprx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_s,
    input  logic              run,
    output logic              done,
    output logic [DATA_W-1:0] byte_o,
    output logic              id_flag,
    output logic              stop_ok
);
    localparam int CNT_W = $clog2(OVS);
    localparam int MID   = OVS / 2 - 1;
    localparam int NBITS = DATA_W + 2;
    localparam int IDX_W = $clog2(NBITS + 1);

    typedef struct packed {
        fr_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W:0]    sh;
        logic               done;
        logic               stop;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        if (!run) begin
            fr_d.st  = FR_IDLE;
            fr_d.cnt = '0;
            fr_d.idx = '0;
        end else if (tick) begin
            case (fr_q.st)
                FR_IDLE: begin
                    if (!line_s) begin
                        fr_d.st  = FR_START;
                        fr_d.cnt = '0;
                    end
                end
                FR_START: begin
                    if (fr_q.cnt == CNT_W'(MID)) begin
                        fr_d.cnt = '0;
                        fr_d.idx = '0;
                        fr_d.st  = line_s ? FR_IDLE : FR_BITS;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                FR_BITS: begin
                    if (fr_q.cnt == CNT_W'(OVS - 1)) begin
                        fr_d.cnt = '0;
                        if (fr_q.idx == IDX_W'(NBITS - 1)) begin
                            fr_d.done = 1'b1;
                            fr_d.stop = line_s;
                            fr_d.st   = FR_IDLE;
                        end else begin
                            fr_d.sh  = {line_s, fr_q.sh[DATA_W:1]};
                            fr_d.idx = fr_q.idx + 1'b1;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                default: fr_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{st: FR_IDLE, default: '0};
        else        fr_q <= fr_d;
    end

    assign done    = fr_q.done;
    assign byte_o  = fr_q.sh[DATA_W-1:0];
    assign id_flag = fr_q.sh[DATA_W];
    assign stop_ok = fr_q.stop;

    // R9: a disabled receiver sits idle on the next cycle
    a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> fr_q.st == FR_IDLE);

    // R8: locked-out engine never leaves idle
    a_r8_lockout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == FR_IDLE && !run) |=> fr_q.st == FR_IDLE);

    // R2: completion only follows the bit-shifting state
    a_r2_done_from_bits: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.done |-> $past(fr_q.st) == FR_BITS);
endmodule

// File: rtl/mprx_regs.sv
module mprx_regs
    import mprx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              fr_done,
    input  logic [DATA_W-1:0] fr_byte,
    input  logic              fr_id,
    input  logic              fr_stop_ok,
    input  logic              line_s,
    output logic              run,
    output logic              full,
    output logic              overrun,
    output logic              frame_err
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              fer;
        logic              rx_on;
        logic              hunt;
    } rg_t;

    rg_t rg_d, rg_q;

    logic stat_wr, ctrl_wr;
    assign stat_wr = wr_en && (wr_addr == A_STAT);
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[REG_W-1:3];

    always_comb begin
        rg_d = rg_q;
        if (stat_wr) begin
            rg_d.full = rg_q.full & wr_data[0];
            rg_d.ovr  = rg_q.ovr  & wr_data[1];
            rg_d.fer  = rg_q.fer  & wr_data[2];
        end
        if (ctrl_wr) begin
            rg_d.rx_on = wr_data[0];
            rg_d.hunt  = wr_data[1];
        end
        if (fr_done && rg_q.rx_on) begin
            if (!fr_stop_ok) begin
                rg_d.fer = 1'b1;
            end else if (rg_d.hunt && !fr_id) begin
                rg_d.hunt = rg_d.hunt;
            end else if (rg_d.full) begin
                rg_d.ovr = 1'b1;
            end else begin
                rg_d.data = fr_byte;
                rg_d.full = 1'b1;
                if (fr_id) rg_d.hunt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (rd_addr)
            A_DATA:  rd_data = REG_W'(rg_q.data);
            A_STAT:  rd_data = REG_W'({line_s, rg_q.fer, rg_q.ovr, rg_q.full});
            A_CTRL:  rd_data = REG_W'({rg_q.hunt, rg_q.rx_on});
            default: rd_data = '0;
        endcase
    end

    assign run       = rg_q.rx_on && !rg_q.ovr && !rg_q.fer;
    assign full      = rg_q.full;
    assign overrun   = rg_q.ovr;
    assign frame_err = rg_q.fer;

    // R6: a held byte is not overwritten while full stays set
    a_r6_keep_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.full && !(stat_wr && !wr_data[0])) |=> $stable(rg_q.data));

    // R5: framing error only leaves through a clearing write
    a_r5_fer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.fer && !(stat_wr && !wr_data[2])) |=> rg_q.fer);

    // R5: overrun only leaves through a clearing write
    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.ovr && !(stat_wr && !wr_data[1])) |=> rg_q.ovr);

    // R3: data frame dropped while hunting
    a_r3_drop_data_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && fr_stop_ok && !fr_id && rg_q.hunt && !stat_wr && !ctrl_wr)
        |=> ($stable(rg_q.data) && $stable(rg_q.full) && $stable(rg_q.ovr)));

    // R4: stored ID frame ends the hunt
    a_r4_id_clears_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && fr_stop_ok && fr_id && rg_q.rx_on && !rg_q.full && !stat_wr && !ctrl_wr)
        |=> (!rg_q.hunt && rg_q.full));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mprx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             os_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             rx_full,
    output logic             rx_overrun,
    output logic             rx_frame_err,
    output logic             line_level
);
    logic              line_s;
    logic              run;
    logic              fr_done;
    logic [DATA_W-1:0] fr_byte;
    logic              fr_id;
    logic              fr_stop_ok;

    mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    mprx_frame #(.OVS(OVS)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .line_s (line_s),
        .run    (run),
        .done   (fr_done),
        .byte_o (fr_byte),
        .id_flag(fr_id),
        .stop_ok(fr_stop_ok)
    );

    mprx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .fr_done   (fr_done),
        .fr_byte   (fr_byte),
        .fr_id     (fr_id),
        .fr_stop_ok(fr_stop_ok),
        .line_s    (line_s),
        .run       (run),
        .full      (rx_full),
        .overrun   (rx_overrun),
        .frame_err (rx_frame_err)
    );

    assign line_level = line_s;
endmodule

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rx_full, rx_overrun, rx_frame_err, line_level;

    int tests = 0;
    int fails = 0;

    bit [7:0] m_data;
    bit       m_full, m_ovr, m_fer, m_on, m_hunt;

    always #4 clk = ~clk;

    mp_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .rx_full(rx_full), .rx_overrun(rx_overrun),
        .rx_frame_err(rx_frame_err), .line_level(line_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        wr(2'd1, v);
        m_full &= v[0]; m_ovr &= v[1]; m_fer &= v[2];
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        wr(2'd2, v);
        m_on = v[0]; m_hunt = v[1];
    endtask

    function automatic void model_frame(bit [7:0] d, bit idf, bit stp);
        if (!m_on || m_ovr || m_fer) return;
        if (!stp) m_fer = 1'b1;
        else if (m_hunt && !idf) return;
        else if (m_full) m_ovr = 1'b1;
        else begin
            m_data = d; m_full = 1'b1;
            if (idf) m_hunt = 1'b0;
        end
    endfunction

    task automatic drive_bit(input bit b);
        @(negedge clk);
        rxd = b;
        repeat (15) @(negedge clk);
    endtask

    task automatic send(input bit [7:0] d, input bit idf, input bit stp);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        drive_bit(idf);
        drive_bit(stp);
        @(negedge clk);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic send_m(input bit [7:0] d, input bit idf, input bit stp);
        model_frame(d, idf, stp);
        send(d, idf, stp);
    endtask

    task automatic verify(input string req);
        logic [7:0] v;
        rd(2'd1, v); chk({req, " status"}, v, {4'b0, 1'b1, m_fer, m_ovr, m_full});
        rd(2'd0, v); chk({req, " data"}, v, m_data);
        rd(2'd2, v); chk({req, " control"}, v, {6'b0, m_hunt, m_on});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5eed_0042));
        m_data = 0; m_full = 0; m_ovr = 0; m_fer = 0; m_on = 0; m_hunt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        verify("R1 reset");

        send_m(8'h6B, 1'b0, 1'b1);
        verify("R9 disabled");

        wr_ctrl(8'h01);
        send_m(8'hA5, 1'b0, 1'b1);
        verify("R2 frame A5");
        wr_stat(8'h06);
        verify("R5 clear full");
        send_m(8'h3C, 1'b0, 1'b1);
        wr_stat(8'hFF);
        verify("R5 write ones no effect");
        send_m(8'h11, 1'b0, 1'b1);
        verify("R6 overrun keeps data");
        send_m(8'hE7, 1'b0, 1'b1);
        verify("R8 locked by overrun");
        wr_stat(8'h00);
        send_m(8'h77, 1'b0, 1'b1);
        verify("R8 resume after clear");
        wr_stat(8'h06);

        wr_ctrl(8'h03);
        send_m(8'h55, 1'b0, 1'b1);
        verify("R3 data dropped while hunting");
        send_m(8'h42, 1'b1, 1'b1);
        verify("R4 ID stored and hunt cleared");
        wr_stat(8'h06);
        send_m(8'h99, 1'b0, 1'b1);
        verify("R4 data after ID");
        wr_stat(8'h06);
        wr_ctrl(8'h03);
        send_m(8'h12, 1'b0, 1'b1);
        verify("R3 rehunt drops data");

        wr_ctrl(8'h01);
        send_m(8'h5A, 1'b0, 1'b0);
        verify("R7 framing error");
        send_m(8'h24, 1'b0, 1'b1);
        verify("R8 locked by framing error");
        @(negedge clk); rxd = 1'b0;
        repeat (40) @(negedge clk);
        rd(2'd1, v); chk("R10 break level", v[3], 0);
        @(negedge clk); rxd = 1'b1;
        repeat (40) @(negedge clk);
        rd(2'd1, v); chk("R10 idle level", v[3], 1);
        wr_stat(8'h00);

        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        verify("R11 noise pulse");
        send_m(8'hC3, 1'b0, 1'b1);
        verify("R11 next frame in step");
        wr_stat(8'h06);

        drive_bit(1'b0);
        for (int i = 0; i < 4; i++) drive_bit(1'b0);
        wr_ctrl(8'h00);
        @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        verify("R9 aborted frame");
        wr_ctrl(8'h01);
        send_m(8'h81, 1'b0, 1'b1);
        verify("R9 receive after re-enable");

        for (int n = 0; n < 50; n++) begin
            bit [7:0] d;
            bit idf, stp;
            if ((m_ovr || m_fer) && ($urandom % 2 == 0)) wr_stat(8'h00);
            if ($urandom % 4 == 0) wr_ctrl({6'b0, 1'($urandom % 2), 1'b1});
            d   = 8'($urandom);
            idf = ($urandom % 3 == 0);
            stp = ($urandom % 10 != 0);
            send_m(d, idf, stp);
            verify("R2 R3 R4 R6 R7 R8 random");
            if ($urandom % 2 == 0) wr_stat(8'h06);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule